// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block watches the two interrupt-mask bits of a processor core: the bit that blocks ordinary interrupts and the bit that blocks the non-maskable request. For each bit it measures how long the core keeps that bit set. It looks at both bits only on cycles where the core signals an instruction boundary. When a bit is first seen set, the block records the value of a free-running cycle counter. When the bit is next seen clear, it computes the elapsed count. It then updates the shortest, longest and most recent duration for that bit.

The two trackers share no state. The statistics are read back through a one-cycle registered read port. A live elapsed count for each bit is also available on output ports at all times, so other logic can watch it.

Top module: `imon_top`

## Requirements
- R1: After reset, every read of either tracker returns 0 for the min, max, last and live fields, `rd_valid_o` is low, and both live ports are 0.
- R2: A run starts at the first sampled cycle (`sample_i`=1) in which the mask bit is 1 and no run is active; that cycle's `cyc_i` is the start. Further sampled cycles with the bit still set do not move the start.
- R3: At the first sampled cycle in which the bit is 0 while a run is active, the duration is `cyc_i` minus the start. The last field is always overwritten with this duration, and the run ends.
- R4: At the end of a run, the min field takes the duration only if it is smaller than the stored min. The max field takes it only if it is larger than the stored max.
- R5: Changes of a mask bit on cycles with `sample_i`=0 have no effect: no run starts or ends on such a cycle.
- R6: Reading either tracker while its run is active reports max as the larger of the stored max and the elapsed count. That larger value is also written into the stored max, and it stays there after the run ends.
- R7: While no run has completed since reset, the min field reports the same value as the max field.
- R8: The two trackers are independent. `rd_sel_i`=0 selects the ordinary-mask tracker (driven by `std_mask_i`), and `rd_sel_i`=1 selects the non-maskable-mask tracker (driven by `nmi_mask_i`).
- R9: Durations are computed modulo 2^CW, so a run that spans a wrap of the cycle counter gives the correct short duration.
- R10: A read issued with `rd_en_i`=1 at a clock edge shows up on `rd_data_o` after that edge, with `rd_valid_o`=1 for exactly that cycle. `rd_valid_o` is 0 after any edge without a read. The field codes in `rd_fld_i` are 0=min, 1=max, 2=last and 3=live elapsed.
- R11: `live_std_o` and `live_nmi_o` show `cyc_i` minus the start while their run is active, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_i | input | CW | Free-running cycle count |
| std_mask_i | input | 1 | Ordinary interrupt mask bit |
| nmi_mask_i | input | 1 | Non-maskable request mask bit |
| sample_i | input | 1 | Instruction-boundary strobe |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 1 | Tracker select (0 ordinary, 1 non-maskable) |
| rd_fld_i | input | 2 | Field select (0 min, 1 max, 2 last, 3 live) |
| rd_data_o | output | CW | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| live_std_o | output | CW | Live elapsed count, ordinary tracker |
| live_nmi_o | output | CW | Live elapsed count, non-maskable tracker |

## Verification
The bench builds the block with CW=8. At that width the counter wraps at 256, so a run that crosses the wrap takes only a few vectors. The min sentinel (255) is also a value a short test can reach. The narrow width brings the wrap case of the modular subtraction into a short test. It also brings in the rule that an untouched min reports max, and the rule that a read during a run raises the stored maximum.

// File: rtl/imon_pkg.sv
package imon_pkg;

    localparam int NTRK    = 2;
    localparam int TRK_STD = 0;
    localparam int TRK_NMI = 1;

    typedef enum logic [1:0] {
        FLD_MIN  = 2'd0,
        FLD_MAX  = 2'd1,
        FLD_LAST = 2'd2,
        FLD_LIVE = 2'd3
    } fld_e;

endpackage

// File: rtl/imon_tracker.sv
module imon_tracker #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_i,
    input  logic          mask_i,
    input  logic [CW-1:0] cyc_i,
    input  logic          rd_hit_i,
    output logic [CW-1:0] rep_min_o,
    output logic [CW-1:0] rep_max_o,
    output logic [CW-1:0] rep_last_o,
    output logic [CW-1:0] live_o
);
    localparam logic [CW-1:0] SENTINEL = {CW{1'b1}};

    typedef struct packed {
        logic          act;
        logic [CW-1:0] start;
        logic [CW-1:0] minv;
        logic [CW-1:0] maxv;
        logic [CW-1:0] last;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] elapsed;
    logic [CW-1:0] eff_max;

    always_comb begin
        elapsed = cyc_i - st_q.start;
        eff_max = (st_q.act && (elapsed > st_q.maxv)) ? elapsed : st_q.maxv;
        st_d    = st_q;
        if (smp_i && mask_i && !st_q.act) begin
            st_d.act   = 1'b1;
            st_d.start = cyc_i;
        end else if (smp_i && !mask_i && st_q.act) begin
            st_d.act  = 1'b0;
            st_d.last = elapsed;
            if (elapsed < st_q.minv) st_d.minv = elapsed;
            if (elapsed > st_q.maxv) st_d.maxv = elapsed;
        end
        if (rd_hit_i && st_q.act && (elapsed > st_d.maxv)) begin
            st_d.maxv = elapsed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act   <= 1'b0;
            st_q.start <= '0;
            st_q.minv  <= SENTINEL;
            st_q.maxv  <= '0;
            st_q.last  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rep_max_o  = eff_max;
    assign rep_min_o  = (st_q.minv == SENTINEL) ? eff_max : st_q.minv;
    assign rep_last_o = st_q.last;
    assign live_o     = st_q.act ? elapsed : '0;

    // R3: last takes the duration of the run that just ended
    p_last_on_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_i && !mask_i && st_q.act) |=> (st_q.last == $past(cyc_i - st_q.start)));

    // R4: stored max never falls, stored min never rises
    p_max_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.maxv >= $past(st_q.maxv)));
    p_min_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.minv <= $past(st_q.minv)));

    // R5: without a strobe or a read nothing moves
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_i && !rd_hit_i) |=> $stable(st_q));

    // R6: a read during a run leaves max at least the elapsed count
    p_read_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && st_q.act) |=> (st_q.maxv >= $past(cyc_i - st_q.start)));

endmodule

// File: rtl/imon_rdmux.sv
module imon_rdmux
    import imon_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en_i,
    input  logic                      rd_sel_i,
    input  logic [1:0]                rd_fld_i,
    input  logic [NTRK-1:0][CW-1:0]   rep_min_i,
    input  logic [NTRK-1:0][CW-1:0]   rep_max_i,
    input  logic [NTRK-1:0][CW-1:0]   rep_last_i,
    input  logic [NTRK-1:0][CW-1:0]   live_i,
    output logic [NTRK-1:0]           rd_hit_o,
    output logic [CW-1:0]             rd_data_o,
    output logic                      rd_valid_o
);
    typedef struct packed {
        logic          valid;
        logic [CW-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    for (genvar t = 0; t < NTRK; t++) begin : g_hit
        assign rd_hit_o[t] = rd_en_i && (int'(rd_sel_i) == t);
    end

    always_comb begin
        rd_d.valid = rd_en_i;
        rd_d.data  = rd_q.data;
        if (rd_en_i) begin
            unique case (fld_e'(rd_fld_i))
                FLD_MIN:  rd_d.data = rep_min_i[rd_sel_i];
                FLD_MAX:  rd_d.data = rep_max_i[rd_sel_i];
                FLD_LAST: rd_d.data = rep_last_i[rd_sel_i];
                default:  rd_d.data = live_i[rd_sel_i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o  = rd_q.data;
    assign rd_valid_o = rd_q.valid;

    // R10: valid follows the request by exactly one edge
    p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);
    p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

endmodule

// File: rtl/imon_top.sv
module imon_top
    import imon_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cyc_i,
    input  logic          std_mask_i,
    input  logic          nmi_mask_i,
    input  logic          sample_i,
    input  logic          rd_en_i,
    input  logic          rd_sel_i,
    input  logic [1:0]    rd_fld_i,
    output logic [CW-1:0] rd_data_o,
    output logic          rd_valid_o,
    output logic [CW-1:0] live_std_o,
    output logic [CW-1:0] live_nmi_o
);
    logic [NTRK-1:0]         mask_v;
    logic [NTRK-1:0]         rd_hit;
    logic [NTRK-1:0][CW-1:0] rep_min, rep_max, rep_last, live;

    assign mask_v[TRK_STD] = std_mask_i;
    assign mask_v[TRK_NMI] = nmi_mask_i;

    for (genvar t = 0; t < NTRK; t++) begin : g_trk
        imon_tracker #(.CW(CW)) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_i      (sample_i),
            .mask_i     (mask_v[t]),
            .cyc_i      (cyc_i),
            .rd_hit_i   (rd_hit[t]),
            .rep_min_o  (rep_min[t]),
            .rep_max_o  (rep_max[t]),
            .rep_last_o (rep_last[t]),
            .live_o     (live[t])
        );
    end

    imon_rdmux #(.CW(CW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .rd_sel_i   (rd_sel_i),
        .rd_fld_i   (rd_fld_i),
        .rep_min_i  (rep_min),
        .rep_max_i  (rep_max),
        .rep_last_i (rep_last),
        .live_i     (live),
        .rd_hit_o   (rd_hit),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    assign live_std_o = live[TRK_STD];
    assign live_nmi_o = live[TRK_NMI];

    // R8: a read of one tracker never touches the other
    p_one_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit));

endmodule

// File: tb/tb_imon_top.sv
module tb_imon_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cyc_i = '0;
    logic          std_mask_i = 1'b0, nmi_mask_i = 1'b0, sample_i = 1'b0;
    logic          rd_en_i = 1'b0, rd_sel_i = 1'b0;
    logic [1:0]    rd_fld_i = 2'd0;
    logic [CW-1:0] rd_data_o, live_std_o, live_nmi_o;
    logic          rd_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    imon_top #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i),
        .std_mask_i(std_mask_i), .nmi_mask_i(nmi_mask_i), .sample_i(sample_i),
        .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_fld_i(rd_fld_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .live_std_o(live_std_o), .live_nmi_o(live_nmi_o)
    );

    typedef struct packed {
        logic       ms;
        logic       mn;
        logic       smp;
        logic       rd;
        logic       sel;
        logic [1:0] fld;
        logic [7:0] cyc;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'd0,  8'd0,  4'd7},  // R7 min shows max
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,8'd0,  8'd0,  4'd1},  // R1
        '{1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,8'd0,  8'd0,  4'd1},  // R1
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd3,8'd0,  8'd0,  4'd1},  // R1
        '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,8'd10, 8'd0,  4'd2},  // R2 start 10
        '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,8'd12, 8'd0,  4'd2},  // R2 no restart
        '{1'b1,1'b0,1'b0,1'b1,1'b0,2'd3,8'd15, 8'd5,  4'd2},  // R2 live 5
        '{1'b1,1'b0,1'b0,1'b1,1'b0,2'd1,8'd15, 8'd5,  4'd6},  // R6
        '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'd30, 8'd0,  4'd5},  // R5 unsampled clear
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd3,8'd31, 8'd21, 4'd5},  // R5 still running
        '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,8'd40, 8'd0,  4'd3},  // R3 end, dur 30
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'd41, 8'd30, 4'd3},  // R3
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'd41, 8'd30, 4'd4},  // R4
        '{1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,8'd41, 8'd0,  4'd8},  // R8 other untouched
        '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,8'd50, 8'd0,  4'd4},  // R4 start 50
        '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,8'd60, 8'd0,  4'd4},  // R4 dur 10
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'd61, 8'd10, 4'd4},  // R4 min drops
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,8'd61, 8'd30, 4'd4},  // R4 max holds
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'd61, 8'd10, 4'd3},  // R3
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'd0,8'd250,8'd0,  4'd9},  // R9 start 250
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'd3,8'd4,  8'd10, 4'd9},  // R9 live across wrap
        '{1'b0,1'b0,1'b1,1'b0,1'b1,2'd0,8'd5,  8'd0,  4'd9},  // R9 end dur 11
        '{1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,8'd6,  8'd11, 4'd9},  // R9
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'd6,  8'd10, 4'd8},  // R8
        '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,8'd100,8'd0,  4'd6},  // R6 start 100
        '{1'b1,1'b0,1'b0,1'b1,1'b0,2'd1,8'd200,8'd100,4'd6},  // R6 raise to 100
        '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,8'd110,8'd0,  4'd6},  // R6 end dur 10
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,8'd111,8'd100,4'd6},  // R6 persists
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'd111,8'd10, 4'd3}   // R3
    };

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_read(input logic sel, input logic [1:0] fld, input string req, input int expv);
        @(negedge clk);
        rd_en_i = 1'b1; rd_sel_i = sel; rd_fld_i = fld;
        @(posedge clk); #1;
        check(req, int'(rd_data_o), expv);
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", int'(rd_valid_o), 0);
        check("R1 live std", int'(live_std_o), 0);
        check("R1 live nmi", int'(live_nmi_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            std_mask_i = TBL[k].ms; nmi_mask_i = TBL[k].mn; sample_i = TBL[k].smp;
            rd_en_i = TBL[k].rd; rd_sel_i = TBL[k].sel; rd_fld_i = TBL[k].fld;
            cyc_i = TBL[k].cyc;
            @(posedge clk); #1;
            if (TBL[k].rd)
                check($sformatf("R%0d vec%0d", TBL[k].req, k), int'(rd_data_o), int'(TBL[k].exp));
        end
        @(negedge clk);
        rd_en_i = 1'b0; sample_i = 1'b0;

        // R10: valid pulse and quiet cycle
        rd_en_i = 1'b1; rd_sel_i = 1'b0; rd_fld_i = 2'd2;
        @(posedge clk); #1;
        check("R10 valid high", int'(rd_valid_o), 1);
        @(negedge clk);
        rd_en_i = 1'b0;
        @(posedge clk); #1;
        check("R10 valid low", int'(rd_valid_o), 0);

        // R11: live ports
        @(negedge clk);
        std_mask_i = 1'b1; sample_i = 1'b1; cyc_i = 8'd20;
        @(posedge clk);
        @(negedge clk);
        sample_i = 1'b0; cyc_i = 8'd27;
        #1;
        check("R11 live std", int'(live_std_o), 7);
        check("R11 live nmi idle", int'(live_nmi_o), 0);

        // R1: reset during an active run clears everything
        @(negedge clk);
        rst_n = 1'b0; std_mask_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 live after reset", int'(live_std_o), 0);
        do_read(1'b0, 2'd1, "R1 max after reset", 0);
        do_read(1'b0, 2'd0, "R7 min after reset", 0);
        do_read(1'b0, 2'd2, "R1 last after reset", 0);
        do_read(1'b1, 2'd1, "R1 nmi max after reset", 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule